// File: doc/BRIEF.md
# Paging Decoder Status and Control Register

This block gives the host one address for two registers. A read returns an 8-bit status byte and a write loads an 8-bit control byte. The status byte gathers information from the decoder core. Some bits are sticky events: call arrivals, buffer drain or overflow, alert expiry and the periodic tick. Others are live levels: out-of-range, and a monitor level taken from either the battery input or the receiver-enable signal. Each field has its own rule for what a host read does to it. A single interrupt output summarises the pending bits, and three of its sources can be masked.

The control byte is held in a register and drives the decoder's command outputs. One of these is a termination request that clears itself. The core sends a one-cycle `term_done` pulse when termination is complete, and the request bit drops.

Top module: `pgdec_stat_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00, `irq` is low and every control output is low.
- R2: A call event with a nonzero code puts that code in status [1:0]. Code 1 means a new call, code 2 means continuous data and code 3 means batch-zero data. A read with no further call queued returns the field to 0.
- R3: A call that arrives while status [1:0] is already nonzero is queued. The read that returns the first code then loads the queued code into [1:0] instead of clearing it.
- R4: While `buf_nonempty` is high, status [3:2] shows 01 (bit 2 set). A read leaves bit 2 set as long as the buffer is still nonempty.
- R5: A falling edge of `buf_nonempty` sets [3:2] to 10 (drained). A `buf_ovf` pulse sets [3:2] to 11. A read always clears bit 3, and clears bit 2 only when the buffer is empty.
- R6: Bit 4 (alert expired) and bit 7 (periodic tick) latch their event pulses and are cleared by every read.
- R7: Bit 5 follows `oor_lvl`, one register stage late. Bit 6 follows `bat_lvl` when control bit 2 is 1 and `rxe_lvl` when it is 0. A read does not clear either bit.
- R8: `irq` is registered one cycle after the status byte. It is the OR of status bits 0 to 4, plus bits 5, 6 and 7 when control bits 5, 6 and 7 respectively are 0. It falls after the read that clears its causes.
- R9: An event pulse that arrives in the same cycle as a read is kept and is returned by the next read.
- R10: A write loads the control byte. Bit 0 drives `term_req`, bit 1 drives `eeprom_wen`, bit 3 drives `rx_force_on` and bit 4 drives `dec_on`. A `term_done` pulse clears bit 0 unless a write arrives in the same cycle.
- R11: `rd_data` takes the status byte as it stood at the read strobe's clock edge, before any clearing. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Status read strobe, one cycle |
| rd_data | output | 8 | Registered status byte returned by the last read |
| wr_stb | input | 1 | Control write strobe |
| wr_data | input | 8 | Control byte to load |
| call_evt | input | 1 | Call decoded pulse |
| call_code | input | 2 | Call type with the event: 1 new, 2 continuous, 3 batch-zero |
| buf_nonempty | input | 1 | Level: buffer read and write pointers differ |
| buf_ovf | input | 1 | Buffer full or overflow pulse |
| alert_evt | input | 1 | Alert time-out pulse |
| timer_evt | input | 1 | Periodic timer pulse |
| oor_lvl | input | 1 | Out-of-range level |
| bat_lvl | input | 1 | Battery monitor level |
| rxe_lvl | input | 1 | Receiver-enable level |
| term_done | input | 1 | Forced termination finished pulse |
| irq | output | 1 | Interrupt request |
| term_req | output | 1 | Forced termination request |
| eeprom_wen | output | 1 | EEPROM programming enable |
| rx_force_on | output | 1 | Keep receiver continuously on |
| dec_on | output | 1 | Decoder on |

## Verification
The assertions assume that `call_evt`, `buf_ovf`, `alert_evt`, `timer_evt` and `term_done` are single-cycle pulses sampled on the rising edge. They also assume that `buf_nonempty` is a level that changes only when the core's pointers move. The stimulus changes every input on the falling clock edge and raises each pulse for exactly one cycle. It keeps the level inputs low during reset, so no checked property sees an event before the first valid edge.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  localparam int STAT_W = 8;
  localparam int CODE_W = 2;

  // status field positions (host software decodes these)
  localparam int S_CALL_LO = 0;
  localparam int S_BUF_LO  = 2;
  localparam int S_ALERT   = 4;
  localparam int S_OOR     = 5;
  localparam int S_MON     = 6;
  localparam int S_TICK    = 7;

  // control field positions
  localparam int C_TERM    = 0;
  localparam int C_EEW     = 1;
  localparam int C_MONSEL  = 2;
  localparam int C_RXON    = 3;
  localparam int C_DECON   = 4;
  localparam int C_MOOR    = 5;
  localparam int C_MMON    = 6;
  localparam int C_MTICK   = 7;

  typedef enum logic [CODE_W-1:0] {
    CALL_NONE   = 2'd0,
    CALL_NEW    = 2'd1,
    CALL_CONT   = 2'd2,
    CALL_BATCH0 = 2'd3
  } call_kind_e;
endpackage

// File: rtl/pgdec_call_track.sv
module pgdec_call_track
  import pgdec_pkg::*;
#(
  parameter int PEND_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_clr,
  input  logic              evt,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] cur_o
);
  localparam int CW = $clog2(PEND_DEPTH + 1);

  logic [CODE_W-1:0]                  cur_q, cur_b, cur_n;
  logic [PEND_DEPTH-1:0][CODE_W-1:0]  pend_q, pend_b, pend_n;
  logic [CW-1:0]                      cnt_q, cnt_b, cnt_n;

  // read side: shift the queue head into the visible field
  always_comb begin
    cur_b  = cur_q;
    pend_b = pend_q;
    cnt_b  = cnt_q;
    if (rd_clr) begin
      if (cnt_q != '0) begin
        cur_b = pend_q[0];
        for (int i = 0; i < PEND_DEPTH - 1; i++) begin
          pend_b[i] = pend_q[i+1];
        end
        pend_b[PEND_DEPTH-1] = CALL_NONE;
        cnt_b = cnt_q - 1'b1;
      end else begin
        cur_b = CALL_NONE;
      end
    end
  end

  // event side: applied after the read, so a same-cycle call survives
  always_comb begin
    cur_n  = cur_b;
    pend_n = pend_b;
    cnt_n  = cnt_b;
    if (evt && (code != CALL_NONE)) begin
      if (cur_b == CALL_NONE) begin
        cur_n = code;
      end else if (cnt_b < CW'(PEND_DEPTH)) begin
        for (int i = 0; i < PEND_DEPTH; i++) begin
          if (CW'(i) == cnt_b) pend_n[i] = code;
        end
        cnt_n = cnt_b + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= CALL_NONE;
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      cur_q  <= cur_n;
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/pgdec_buf_track.sv
module pgdec_buf_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_clr,
  input  logic       nonempty,
  input  logic       ovf,
  output logic [1:0] st_o
);
  logic avail_q, flag_q, prev_q;
  logic avail_b, flag_b, avail_n, flag_n;
  logic drain;

  assign drain = prev_q & ~nonempty;

  always_comb begin
    // read clears the event bit, and the data bit only once empty
    flag_b  = rd_clr ? 1'b0 : flag_q;
    avail_b = rd_clr ? (avail_q & nonempty) : avail_q;
    flag_n  = flag_b;
    avail_n = avail_b;
    if (ovf) begin
      flag_n  = 1'b1;
      avail_n = 1'b1;
    end else if (drain) begin
      flag_n  = 1'b1;
      avail_n = flag_b ? avail_b : 1'b0;
    end else if (nonempty && !flag_b) begin
      avail_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= 1'b0;
      flag_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      avail_q <= avail_n;
      flag_q  <= flag_n;
      prev_q  <= nonempty;
    end
  end

  assign st_o = {flag_q, avail_q};
endmodule

// File: rtl/pgdec_ctrl_reg.sv
module pgdec_ctrl_reg
  import pgdec_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         term_done,
  output logic [W-1:0] ctrl_o
);
  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_stb) begin
      ctrl_q <= wr_data;
    end else if (term_done) begin
      ctrl_q[C_TERM] <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pgdec_stat_ctrl.sv
module pgdec_stat_ctrl
  import pgdec_pkg::*;
#(
  parameter int PEND_DEPTH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  output logic [STAT_W-1:0] rd_data,
  input  logic              wr_stb,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              call_evt,
  input  logic [CODE_W-1:0] call_code,
  input  logic              buf_nonempty,
  input  logic              buf_ovf,
  input  logic              alert_evt,
  input  logic              timer_evt,
  input  logic              oor_lvl,
  input  logic              bat_lvl,
  input  logic              rxe_lvl,
  input  logic              term_done,
  output logic              irq,
  output logic              term_req,
  output logic              eeprom_wen,
  output logic              rx_force_on,
  output logic              dec_on
);
  logic [STAT_W-1:0] ctrl_q;
  logic [CODE_W-1:0] call_st;
  logic [1:0]        buf_st;
  logic              alert_q, tick_q, oor_q, mon_q;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] en_mask;
  logic [STAT_W-1:0] rd_q;
  logic              irq_q;

  pgdec_ctrl_reg #(.W(STAT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .term_done(term_done), .ctrl_o(ctrl_q)
  );

  pgdec_call_track #(.PEND_DEPTH(PEND_DEPTH)) u_call (
    .clk(clk), .rst(rst), .rd_clr(rd_stb), .evt(call_evt),
    .code(call_code), .cur_o(call_st)
  );

  pgdec_buf_track u_buf (
    .clk(clk), .rst(rst), .rd_clr(rd_stb), .nonempty(buf_nonempty),
    .ovf(buf_ovf), .st_o(buf_st)
  );

  assign status = {tick_q, mon_q, oor_q, alert_q, buf_st, call_st};

  // only the level and tick sources can be masked
  always_comb begin
    en_mask          = '1;
    en_mask[S_OOR]   = ~ctrl_q[C_MOOR];
    en_mask[S_MON]   = ~ctrl_q[C_MMON];
    en_mask[S_TICK]  = ~ctrl_q[C_MTICK];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_q <= 1'b0;
      tick_q  <= 1'b0;
      oor_q   <= 1'b0;
      mon_q   <= 1'b0;
      rd_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      alert_q <= (alert_q & ~rd_stb) | alert_evt;
      tick_q  <= (tick_q & ~rd_stb) | timer_evt;
      oor_q   <= oor_lvl;
      mon_q   <= ctrl_q[C_MONSEL] ? bat_lvl : rxe_lvl;
      if (rd_stb) rd_q <= status;
      irq_q   <= |(status & en_mask);
    end
  end

  assign rd_data     = rd_q;
  assign irq         = irq_q;
  assign term_req    = ctrl_q[C_TERM];
  assign eeprom_wen  = ctrl_q[C_EEW];
  assign rx_force_on = ctrl_q[C_RXON];
  assign dec_on      = ctrl_q[C_DECON];
endmodule

// File: rtl/pgdec_stat_ctrl_chk.sv
module pgdec_stat_ctrl_chk
  import pgdec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [STAT_W-1:0] wr_data,
  input logic              term_done,
  input logic              timer_evt,
  input logic              buf_ovf,
  input logic              call_evt,
  input logic [CODE_W-1:0] call_code,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] rd_data,
  input logic              irq,
  input logic              term_req
);
  AST_TERM_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (term_done && !wr_stb) |=> !term_req); // R10
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst) wr_stb |=> (term_req == $past(wr_data[C_TERM]))); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_stb |=> $stable(rd_data)); // R11
  AST_TICK_KEPT: assert property (@(posedge clk) disable iff (rst) timer_evt |=> status[S_TICK]); // R9
  AST_CALL_SEEN: assert property (@(posedge clk) disable iff (rst) (call_evt && call_code != CALL_NONE) |=> (status[1:0] != CALL_NONE)); // R2
  AST_OVF_BOTH: assert property (@(posedge clk) disable iff (rst) buf_ovf |=> (status[3:2] == 2'b11)); // R5
  AST_IRQ_ALERT: assert property (@(posedge clk) disable iff (rst) status[S_ALERT] |=> irq); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) (status == '0) |=> !irq); // R8
endmodule

bind pgdec_stat_ctrl pgdec_stat_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
  .term_done(term_done), .timer_evt(timer_evt), .buf_ovf(buf_ovf),
  .call_evt(call_evt), .call_code(call_code), .status(status),
  .rd_data(rd_data), .irq(irq), .term_req(term_req)
);

// File: tb/pgdec_stat_ctrl_tb.sv
`timescale 1ns/1ps
module pgdec_stat_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_stb = 0, wr_stb = 0, call_evt = 0, buf_nonempty = 0, buf_ovf = 0;
  logic       alert_evt = 0, timer_evt = 0, oor_lvl = 0, bat_lvl = 0, rxe_lvl = 0, term_done = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] call_code = 0;
  logic [7:0] rd_data;
  logic       irq, term_req, eeprom_wen, rx_force_on, dec_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgdec_stat_ctrl u_dut (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb),
    .wr_data(wr_data), .call_evt(call_evt), .call_code(call_code),
    .buf_nonempty(buf_nonempty), .buf_ovf(buf_ovf), .alert_evt(alert_evt),
    .timer_evt(timer_evt), .oor_lvl(oor_lvl), .bat_lvl(bat_lvl), .rxe_lvl(rxe_lvl),
    .term_done(term_done), .irq(irq), .term_req(term_req), .eeprom_wen(eeprom_wen),
    .rx_force_on(rx_force_on), .dec_on(dec_on)
  );

  localparam logic [3:0] OP_RD = 0, OP_CALL = 1, OP_BUF = 2, OP_OVF = 3,
                         OP_ALR = 4, OP_TMR = 5, OP_WR = 6, OP_IRQ = 7;
  localparam int NV = 31;
  // {requirement, op, argument, expected}
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, OP_RD,   8'h00, 8'h00},
    {4'd2, OP_CALL, 8'h01, 8'h00}, {4'd2, OP_RD, 8'h00, 8'h01}, {4'd2, OP_RD, 8'h00, 8'h00},
    {4'd3, OP_CALL, 8'h02, 8'h00}, {4'd3, OP_CALL, 8'h03, 8'h00},
    {4'd3, OP_RD,   8'h00, 8'h02}, {4'd3, OP_RD, 8'h00, 8'h03}, {4'd3, OP_RD, 8'h00, 8'h00},
    {4'd4, OP_BUF,  8'h01, 8'h00}, {4'd4, OP_RD, 8'h00, 8'h04}, {4'd4, OP_RD, 8'h00, 8'h04},
    {4'd5, OP_BUF,  8'h00, 8'h00}, {4'd5, OP_RD, 8'h00, 8'h08}, {4'd5, OP_RD, 8'h00, 8'h00},
    {4'd5, OP_OVF,  8'h00, 8'h00}, {4'd5, OP_RD, 8'h00, 8'h0C}, {4'd5, OP_RD, 8'h00, 8'h00},
    {4'd6, OP_ALR,  8'h00, 8'h00}, {4'd6, OP_TMR, 8'h00, 8'h00},
    {4'd6, OP_RD,   8'h00, 8'h90}, {4'd6, OP_RD, 8'h00, 8'h00},
    {4'd8, OP_CALL, 8'h01, 8'h00}, {4'd8, OP_IRQ, 8'h00, 8'h01},
    {4'd8, OP_RD,   8'h00, 8'h01}, {4'd8, OP_IRQ, 8'h00, 8'h00},
    {4'd8, OP_WR,   8'h80, 8'h00}, {4'd8, OP_TMR, 8'h00, 8'h00}, {4'd8, OP_IRQ, 8'h00, 8'h00},
    {4'd6, OP_RD,   8'h00, 8'h80}, {4'd8, OP_WR, 8'h00, 8'h00}
  };

  function automatic string rname(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_rd(output logic [7:0] v);
    rd_stb = 1; @(posedge clk); @(negedge clk); rd_stb = 0; v = rd_data;
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_stb = 1; wr_data = d; @(posedge clk); @(negedge clk); wr_stb = 0;
  endtask

  task automatic run_vec(input logic [23:0] v);
    logic [7:0] got;
    string req;
    req = rname(int'(v[23:20]));
    case (v[19:16])
      OP_RD:   begin do_rd(got); chk(req, got, v[7:0]); end
      OP_CALL: begin call_evt = 1; call_code = v[9:8]; idle(1); call_evt = 0; end
      OP_BUF:  begin buf_nonempty = v[8]; idle(1); end
      OP_OVF:  begin buf_ovf = 1; idle(1); buf_ovf = 0; end
      OP_ALR:  begin alert_evt = 1; idle(1); alert_evt = 0; end
      OP_TMR:  begin timer_evt = 1; idle(1); timer_evt = 0; end
      OP_WR:   do_wr(v[15:8]);
      default: begin idle(1); chk(req, {7'd0, irq}, v[7:0]); end
    endcase
  endtask

  initial begin
    logic [7:0] got;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1", rd_data, 8'h00);
    chk("R1", {3'd0, irq, term_req, eeprom_wen, rx_force_on, dec_on}, 8'h00);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R7 out-of-range level, not cleared by read
    oor_lvl = 1; idle(2);
    do_rd(got); chk("R7", got, 8'h20);
    do_rd(got); chk("R7", got, 8'h20);
    idle(1); chk("R8", {7'd0, irq}, 8'h01);
    do_wr(8'h20); idle(2); chk("R8", {7'd0, irq}, 8'h00);
    oor_lvl = 0; idle(2);
    do_rd(got); chk("R7", got, 8'h00);
    do_wr(8'h00);
    // R7 monitor source select: 0 picks rxe, 1 picks bat
    rxe_lvl = 1; idle(2);
    do_rd(got); chk("R7", got, 8'h40);
    do_wr(8'h04); idle(2);
    do_rd(got); chk("R7", got, 8'h00);
    bat_lvl = 1; idle(2);
    do_rd(got); chk("R7", got, 8'h40);
    // R11 read data holds until the next read
    timer_evt = 1; idle(1); timer_evt = 0; idle(1);
    chk("R11", rd_data, 8'h40);
    do_rd(got); chk("R11", got, 8'hC0);
    do_wr(8'h44); idle(2); chk("R8", {7'd0, irq}, 8'h00);
    bat_lvl = 0; rxe_lvl = 0; do_wr(8'h00); idle(2);
    do_rd(got); chk("R7", got, 8'h00);

    // R9 events in the same cycle as a read
    rd_stb = 1; alert_evt = 1; call_evt = 1; call_code = 2'd1;
    @(posedge clk); @(negedge clk);
    rd_stb = 0; alert_evt = 0; call_evt = 0;
    chk("R9", rd_data, 8'h00);
    do_rd(got); chk("R9", got, 8'h11);
    do_rd(got); chk("R9", got, 8'h00);

    // R10 control outputs and self-clearing termination
    do_wr(8'h1B);
    chk("R10", {4'd0, term_req, eeprom_wen, rx_force_on, dec_on}, 8'h0F);
    idle(3);
    chk("R10", {7'd0, term_req}, 8'h01);
    term_done = 1; idle(1); term_done = 0;
    chk("R10", {4'd0, term_req, eeprom_wen, rx_force_on, dec_on}, 8'h07);
    do_wr(8'h00);
    chk("R10", {4'd0, term_req, eeprom_wen, rx_force_on, dec_on}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule